// File: doc/BRIEF.md
# Transmit Descriptor Ring Index Tracker

This block keeps the controller's side of a transmit descriptor ring. The host posts work by writing a new producer index into a mailbox register. The block compares that index with its own pointers and asks for descriptor fetches, one entry at a time, until every posted entry has been requested. A fetched descriptor is later reported as finished on a completion strobe, and each one moves the consumer index forward by one. All indices wrap modulo a power-of-two ring size. The ring is empty when the consumer and producer indices are equal.

Completions are not reported to the host one by one. The block counts finished descriptors. When the count reaches a programmable limit, it asks for a status-block writeback that carries the consumer index. If completions stay pending for a programmable number of timer ticks before the limit is reached, it asks anyway. The writeback request is held until it is acknowledged, and an interrupt pulse follows the acknowledge. A mailbox write that would overrun the free space of the ring is rejected and reported on an error strobe.

Top module: `srt_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `fetch_req`, `status_req`, `irq` and `overrun_err` are 0 and `status_idx` is 0.
- R2: After an accepted mailbox write, `fetch_req` is 1 from the next cycle. `fetch_idx` starts at the previous producer index and steps up by one, modulo the ring size, for each cycle in which `fetch_req` and `fetch_ack` are both 1. It holds its value otherwise.
- R3: `fetch_req` is 0 once every posted entry up to the producer index has been fetched.
- R4: A mailbox write is rejected when (new − consumer) mod N < (producer − consumer) mod N, which means it posts more entries than the ring has free. A rejected write raises `overrun_err` for exactly the next cycle and leaves the producer index unchanged, so no further fetch is requested.
- R5: A `desc_done` pulse while no fetched descriptor is waiting to complete is ignored. It does not advance the consumer index and is not counted toward coalescing.
- R6: When the number of counted completions since the last writeback reaches `coal_lim`, `status_req` rises at the second clock edge after the completion that reached the limit. `status_idx` then equals the consumer index.
- R7: While at least one completion is pending and no writeback is outstanding, `tick` pulses are counted. Once `tmo_lim` ticks have been counted, `status_req` rises at the next edge even when `coal_lim` has not been reached.
- R8: `status_req` and `status_idx` hold their values until `status_ack` is sampled 1.
- R9: `irq` is a single-cycle pulse in the cycle after the one in which `status_req` and `status_ack` are both 1.
- R10: The producer, fetch and consumer indices wrap modulo the ring size. Fetch indices and the reported consumer index continue through the wrap in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mbox_wr | input | 1 | Mailbox write strobe carrying a new producer index |
| mbox_idx | input | IDX_W | Producer index written by the host |
| fetch_req | output | 1 | A posted descriptor is waiting to be fetched |
| fetch_idx | output | IDX_W | Ring slot of the descriptor to fetch |
| fetch_ack | input | 1 | Fetch of `fetch_idx` accepted |
| desc_done | input | 1 | One fetched descriptor finished |
| tick | input | 1 | Coalescing timer tick |
| coal_lim | input | IDX_W+1 | Completion count that triggers a writeback |
| tmo_lim | input | TMO_W | Tick count that triggers a writeback |
| status_req | output | 1 | Status writeback request |
| status_idx | output | IDX_W | Consumer index to write into the status block |
| status_ack | input | 1 | Status writeback done |
| irq | output | 1 | Interrupt pulse after a writeback |
| overrun_err | output | 1 | Rejected mailbox write |

## Verification
A producer or fetch pointer that drifts shows up on `fetch_idx` or as a wrong `fetch_req` level in the very next cycle. The bench therefore compares every requested slot, including across the wrap. A consumer index or pending count that is wrong stays hidden until the next writeback, so each scenario ends in a writeback whose `status_idx` and launch cycle are checked exactly. A completion that was miscounted, or a timer that ticked when it should not have, changes the cycle in which `status_req` rises.

// File: rtl/srt_pkg.sv
package srt_pkg;

    // Index width for a ring of n entries (n is expected to be a power of two).
    function automatic int unsigned idx_bits(int unsigned n);
        int unsigned w;
        w = 1;
        while ((32'd1 << w) < n) w = w + 1;
        return w;
    endfunction

endpackage

// File: rtl/srt_ring.sv
module srt_ring #(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mbox_wr,
    input  logic [IDX_W-1:0] mbox_idx,
    input  logic             fetch_ack,
    input  logic             desc_done,
    output logic             fetch_req,
    output logic [IDX_W-1:0] fetch_idx,
    output logic [IDX_W-1:0] cons_idx,
    output logic             done_ok,
    output logic             overrun_err
);

    typedef struct packed {
        logic [IDX_W-1:0] prod;
        logic [IDX_W-1:0] fptr;
        logic [IDX_W-1:0] cons;
        logic             err;
    } ring_s;

    ring_s ring_d, ring_q;

    // Forward distance from a to b; the subtraction wraps at the ring size.
    function automatic logic [IDX_W-1:0] fwd(input logic [IDX_W-1:0] a,
                                             input logic [IDX_W-1:0] b);
        return b - a;
    endfunction

    always_comb begin
        ring_d     = ring_q;
        ring_d.err = 1'b0;

        if (mbox_wr) begin
            if (fwd(ring_q.cons, mbox_idx) < fwd(ring_q.cons, ring_q.prod)) begin
                ring_d.err = 1'b1;
            end else begin
                ring_d.prod = mbox_idx;
            end
        end

        fetch_req = (ring_q.fptr != ring_q.prod);
        fetch_idx = ring_q.fptr;
        if (fetch_req && fetch_ack) begin
            ring_d.fptr = ring_q.fptr + 1'b1;
        end

        done_ok = desc_done && (ring_q.cons != ring_q.fptr);
        if (done_ok) begin
            ring_d.cons = ring_q.cons + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign cons_idx    = ring_q.cons;
    assign overrun_err = ring_q.err;

    // R2: a pending fetch holds its slot until accepted
    a_r2_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_idx)));

    // R4: a rejected write leaves the producer index untouched
    a_r4_reject_keeps_prod: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |-> (ring_q.prod == $past(ring_q.prod)));

    // R5: the consumer never passes the fetch pointer, which never passes the producer
    a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd(ring_q.cons, ring_q.fptr) <= fwd(ring_q.cons, ring_q.prod)));

endmodule

// File: rtl/srt_coal.sv
module srt_coal #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_ok,
    input  logic [IDX_W-1:0] cons_idx,
    input  logic             tick,
    input  logic [CNT_W-1:0] coal_lim,
    input  logic [TMO_W-1:0] tmo_lim,
    input  logic             status_ack,
    output logic             status_req,
    output logic [IDX_W-1:0] status_idx,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] pend;
        logic [TMO_W-1:0] tmo;
        logic             req;
        logic [IDX_W-1:0] idx;
        logic             irq;
    } coal_s;

    coal_s coal_d, coal_q;
    logic  launch;

    always_comb begin
        coal_d     = coal_q;
        coal_d.irq = coal_q.req && status_ack;
        if (coal_q.req && status_ack) begin
            coal_d.req = 1'b0;
        end

        launch = !coal_q.req && (coal_q.pend != '0) &&
                 ((coal_q.pend >= coal_lim) || (coal_q.tmo >= tmo_lim));

        if (launch) begin
            coal_d.req  = 1'b1;
            coal_d.idx  = cons_idx;
            coal_d.pend = done_ok ? CNT_W'(1) : '0;
            coal_d.tmo  = '0;
        end else begin
            if (done_ok && (coal_q.pend != '1)) begin
                coal_d.pend = coal_q.pend + 1'b1;
            end
            if (tick && !coal_q.req && (coal_q.pend != '0) && (coal_q.tmo != '1)) begin
                coal_d.tmo = coal_q.tmo + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coal_q <= '0;
        end else begin
            coal_q <= coal_d;
        end
    end

    assign status_req = coal_q.req;
    assign status_idx = coal_q.idx;
    assign irq        = coal_q.irq;

    // R8: request and index hold until acknowledged
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status_req && !status_ack) |=> (status_req && $stable(status_idx)));

    // R9: an acknowledged writeback is followed by the interrupt
    a_r9_irq_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (status_req && status_ack) |=> irq);

    // R9: no interrupt without an acknowledge in the cycle before
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(status_req && status_ack));

    // R9: the interrupt lasts a single cycle
    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: rtl/srt_tracker.sv
module srt_tracker #(
    parameter int unsigned RING_SZ = 16,
    parameter int unsigned TMO_W   = 8,
    localparam int unsigned IDX_W  = srt_pkg::idx_bits(RING_SZ),
    localparam int unsigned CNT_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mbox_wr,
    input  logic [IDX_W-1:0] mbox_idx,
    output logic             fetch_req,
    output logic [IDX_W-1:0] fetch_idx,
    input  logic             fetch_ack,
    input  logic             desc_done,
    input  logic             tick,
    input  logic [CNT_W-1:0] coal_lim,
    input  logic [TMO_W-1:0] tmo_lim,
    output logic             status_req,
    output logic [IDX_W-1:0] status_idx,
    input  logic             status_ack,
    output logic             irq,
    output logic             overrun_err
);

    logic [IDX_W-1:0] cons_idx;
    logic             done_ok;

    srt_ring #(.IDX_W(IDX_W)) i_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .mbox_wr    (mbox_wr),
        .mbox_idx   (mbox_idx),
        .fetch_ack  (fetch_ack),
        .desc_done  (desc_done),
        .fetch_req  (fetch_req),
        .fetch_idx  (fetch_idx),
        .cons_idx   (cons_idx),
        .done_ok    (done_ok),
        .overrun_err(overrun_err)
    );

    srt_coal #(.IDX_W(IDX_W), .CNT_W(CNT_W), .TMO_W(TMO_W)) i_coal (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_ok   (done_ok),
        .cons_idx  (cons_idx),
        .tick      (tick),
        .coal_lim  (coal_lim),
        .tmo_lim   (tmo_lim),
        .status_ack(status_ack),
        .status_req(status_req),
        .status_idx(status_idx),
        .irq       (irq)
    );

    // R6: a writeback reports the index the ring reached, never one beyond it
    a_r6_idx_reported: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_req) |-> (status_idx == $past(cons_idx)));

endmodule

// File: tb/test_srt_tracker.sv
module test_srt_tracker;

    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mbox_wr;
    logic [3:0] mbox_idx;
    logic       fetch_req;
    logic [3:0] fetch_idx;
    logic       fetch_ack;
    logic       desc_done;
    logic       tick;
    logic [4:0] coal_lim;
    logic [7:0] tmo_lim;
    logic       status_req;
    logic [3:0] status_idx;
    logic       status_ack;
    logic       irq;
    logic       overrun_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    srt_tracker #(.RING_SZ(N), .TMO_W(8)) i_srt_tracker (
        .clk(clk), .rst_n(rst_n), .mbox_wr(mbox_wr), .mbox_idx(mbox_idx),
        .fetch_req(fetch_req), .fetch_idx(fetch_idx), .fetch_ack(fetch_ack),
        .desc_done(desc_done), .tick(tick), .coal_lim(coal_lim), .tmo_lim(tmo_lim),
        .status_req(status_req), .status_idx(status_idx), .status_ack(status_ack),
        .irq(irq), .overrun_err(overrun_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic post(input int idx);
        mbox_wr  = 1'b1;
        mbox_idx = 4'(idx);
        step();
        mbox_wr  = 1'b0;
    endtask

    task automatic fetch_n(input int n, input int start);
        for (int i = 0; i < n; i++) begin
            check("R2 fetch_req", int'(fetch_req), 1);
            check("R2/R10 fetch_idx", int'(fetch_idx), (start + i) % N);
            fetch_ack = 1'b1;
            step();
            fetch_ack = 1'b0;
        end
        check("R3 fetch_req idle", int'(fetch_req), 0);
    endtask

    task automatic complete(input int n);
        for (int i = 0; i < n; i++) begin
            desc_done = 1'b1;
            step();
        end
        desc_done = 1'b0;
    endtask

    task automatic tick_once();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic ack_and_irq();
        status_ack = 1'b1;
        step();
        status_ack = 1'b0;
        check("R9 irq pulse", int'(irq), 1);
        check("R9 req dropped", int'(status_req), 0);
        step();
        check("R9 irq single", int'(irq), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mbox_wr = 0; mbox_idx = 0; fetch_ack = 0; desc_done = 0;
        tick = 0; status_ack = 0; coal_lim = 5'd31; tmo_lim = 8'd255;
        step(); step();
        check("R1 fetch_req", int'(fetch_req), 0);
        check("R1 status_req", int'(status_req), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 overrun_err", int'(overrun_err), 0);
        rst_n = 1'b1;
        step();
        check("R1 status_idx", int'(status_idx), 0);
        check("R1 fetch_req after", int'(fetch_req), 0);
    endtask

    task automatic t_post_three();
        post(3);
        fetch_n(3, 0);
    endtask

    task automatic t_count_coalesce();
        coal_lim = 5'd3; tmo_lim = 8'd200;
        complete(2);
        step();
        check("R6 below limit", int'(status_req), 0);
        complete(1);
        check("R6 not yet", int'(status_req), 0);
        step();
        check("R6 req raised", int'(status_req), 1);
        check("R6 status_idx", int'(status_idx), 3);
        step(); step(); step();
        check("R8 req held", int'(status_req), 1);
        check("R8 idx held", int'(status_idx), 3);
        ack_and_irq();
    endtask

    task automatic t_spurious_done();
        complete(1);
        coal_lim = 5'd1; tmo_lim = 8'd2;
        for (int i = 0; i < 5; i++) tick_once();
        step();
        check("R5 spurious done ignored", int'(status_req), 0);
    endtask

    task automatic t_timeout();
        post(5);
        fetch_n(2, 3);
        coal_lim = 5'd8; tmo_lim = 8'd3;
        complete(1);
        tick_once(); tick_once();
        check("R7 before timeout", int'(status_req), 0);
        tick_once();
        check("R7 limit reached", int'(status_req), 0);
        step();
        check("R7 timeout req", int'(status_req), 1);
        check("R7 status_idx", int'(status_idx), 4);
        ack_and_irq();
    endtask

    task automatic t_overrun_wrap();
        post(4);
        check("R4 overrun_err", int'(overrun_err), 1);
        check("R4 no fetch", int'(fetch_req), 0);
        step();
        check("R4 err one cycle", int'(overrun_err), 0);
        check("R4 still no fetch", int'(fetch_req), 0);
        post(3);
        check("R4 legal write ok", int'(overrun_err), 0);
        fetch_n(14, 5);
        coal_lim = 5'd14; tmo_lim = 8'd255;
        complete(13);
        step();
        check("R6 under 14", int'(status_req), 0);
        complete(1);
        step();
        check("R10 req after wrap", int'(status_req), 1);
        check("R10 wrapped status_idx", int'(status_idx), 2);
        ack_and_irq();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_post_three();
        t_count_coalesce();
        t_spurious_done();
        t_timeout();
        t_overrun_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule